// File: doc/BRIEF.md
# DRAM Row Retirement Column Sweeper

When a DRAM error is reported, the whole row that holds it should be taken out of service. This block takes the failing DRAM error address and steps through every value of the 5-bit column field, which sits in address bits 5:1. For each value it builds an address in which only those bits are replaced, then sends it to an external address translator. Each translation that succeeds is turned into a page frame number. If that page is online and not yet poisoned, the block sends it out as a page-retire request.

Software or a sequencer starts a sweep by pulsing `start_i` with the error address on `err_addr_i`. The block keeps `busy_o` high while it works and pulses `done_o` when it has finished. The translator is reached through a request channel with valid/ready and a response channel with a valid strobe. Retire requests leave through a valid/ready port. Only one column is in flight at any time: the block does not issue the next translation until the current result has been dropped or its retire request has been consumed.

Top module: `row_col_sweeper`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `xl_req_valid_o` and `ret_valid_o` are all low.
- R2: When `start_i` is seen while idle, `err_addr_i` is captured. Each translation request carries the captured address with bits 5:1 replaced by the column count and every other bit unchanged. Column counts are issued in ascending order, 0 to 31.
- R3: Each sweep issues exactly 32 translation requests. No new request is raised while a response is still awaited or a retire request is still pending.
- R4: A response with `xl_rsp_err_i` high produces no retire request, and the sweep moves on to the next column.
- R5: The retire page frame number equals the translated physical address shifted right by `PAGE_SHIFT` bits (default 12).
- R6: A response with `xl_rsp_online_i` low or `xl_rsp_poisoned_i` high produces no retire request.
- R7: While `ret_valid_o` is high and `ret_ready_i` is low, `ret_valid_o` stays high and `ret_pfn_o` does not change.
- R8: `done_o` is high for exactly one cycle, after column 31 has been handled. `busy_o` is high from the cycle after start through the done cycle, and low afterwards.
- R9: A `start_i` pulse while busy has no effect: the captured address is kept, and no extra sweep follows.
- R10: While `xl_req_valid_o` is high and `xl_req_ready_i` is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (ignored while busy) |
| err_addr_i | input | ADDR_W | Failing DRAM error address |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse when the sweep ends |
| xl_req_valid_o | output | 1 | Translation request valid |
| xl_req_ready_i | input | 1 | Translator accepts request |
| xl_req_addr_o | output | ADDR_W | Address with column substituted |
| xl_rsp_valid_i | input | 1 | Translation response valid |
| xl_rsp_err_i | input | 1 | Translation failed |
| xl_rsp_pa_i | input | PA_W | Translated physical address |
| xl_rsp_online_i | input | 1 | Page is online |
| xl_rsp_poisoned_i | input | 1 | Page already poisoned |
| ret_valid_o | output | 1 | Retire request valid |
| ret_ready_i | input | 1 | Retire consumer ready |
| ret_pfn_o | output | PA_W-PAGE_SHIFT | Page frame number to retire |

## Verification
The bench uses an error address whose low bit and column bits are set. A design that overwrote bit 0 or failed to clear the old column would then send wrong request addresses. Responses mix errors, offline pages and poisoned pages, so a filter with a missing or inverted term would emit a retire that is not expected, or lose one that is. Backpressure on both the request and the retire side catches outputs that drift while stalled, or a sweep that runs ahead of an unconsumed retire. A second start in the middle of a sweep, with a different address, exposes a design that captures the new address or restarts the sweep. The count of requests and of done pulses catches an off-by-one at column 31.

// File: rtl/col_sweep_pkg.sv
package col_sweep_pkg;
  typedef enum logic [2:0] {
    SW_IDLE,
    SW_REQ,
    SW_WAIT,
    SW_EMIT,
    SW_FIN
  } sweep_state_e;
endpackage

// File: rtl/col_insert.sv
module col_insert #(
  parameter int ADDR_W = 48,
  parameter int COL_LO = 1,
  parameter int COL_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int COL_HI = COL_LO + COL_W - 1;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b >= COL_LO && b <= COL_HI) begin : g_col
      assign addr_o[b] = col_i[b-COL_LO];
    end else begin : g_keep
      assign addr_o[b] = base_i[b];
    end
  end
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import col_sweep_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int COL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic              req_ready_i,
  input  logic              rsp_valid_i,
  input  logic              keep_i,
  input  logic              ret_fire_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_valid_o,
  output logic              rsp_take_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam logic [COL_W-1:0] COL_LAST = '1;

  sweep_state_e state_q, state_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [ADDR_W-1:0] base_q;
  logic              step;

  assign rsp_take_o = (state_q == SW_WAIT) && rsp_valid_i;
  // column finished: dropped result or consumed retire
  assign step = (rsp_take_o && !keep_i) || ((state_q == SW_EMIT) && ret_fire_i);

  always_comb begin
    state_d = state_q;
    col_d   = col_q;
    unique case (state_q)
      SW_IDLE: if (start_i) begin
        state_d = SW_REQ;
        col_d   = '0;
      end
      SW_REQ:  if (req_ready_i) state_d = SW_WAIT;
      SW_WAIT: if (rsp_valid_i && keep_i) state_d = SW_EMIT;
      SW_EMIT: ;
      SW_FIN:  state_d = SW_IDLE;
      default: state_d = SW_IDLE;
    endcase
    if (step) begin
      if (col_q == COL_LAST) begin
        state_d = SW_FIN;
      end else begin
        state_d = SW_REQ;
        col_d   = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      col_q   <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      col_q   <= col_d;
      if (state_q == SW_IDLE && start_i) base_q <= err_addr_i;
    end
  end

  assign busy_o      = (state_q != SW_IDLE);
  assign done_o      = (state_q == SW_FIN);
  assign req_valid_o = (state_q == SW_REQ);
  assign col_o       = col_q;
  assign base_o      = base_q;

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(col_o) && $stable(base_o));
  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(base_o));
  assert_one_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_ready_i |=> !req_valid_o);
endmodule

// File: rtl/page_filter.sv
module page_filter #(
  parameter int PA_W       = 52,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  take_i,
  input  logic                  err_i,
  input  logic                  online_i,
  input  logic                  poisoned_i,
  input  logic [PA_W-1:0]       pa_i,
  input  logic                  ready_i,
  output logic                  keep_o,
  output logic                  fire_o,
  output logic                  valid_o,
  output logic [PFN_W-1:0]      pfn_o
);
  localparam int PFN_W = PA_W - PAGE_SHIFT;

  logic             valid_q;
  logic [PFN_W-1:0] pfn_q;

  assign keep_o = !err_i && online_i && !poisoned_i;
  assign fire_o = valid_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pfn_q   <= '0;
    end else if (take_i && keep_o) begin
      valid_q <= 1'b1;
      pfn_q   <= pa_i[PA_W-1:PAGE_SHIFT];
    end else if (fire_o) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign pfn_o   = pfn_q;

  assert_ret_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(pfn_o));
  assert_err_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && err_i |=> !valid_o);
  assert_page_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && (!online_i || poisoned_i) |=> !valid_o);
endmodule

// File: rtl/row_col_sweeper.sv
module row_col_sweeper #(
  parameter int ADDR_W     = 48,
  parameter int PA_W       = 52,
  parameter int PAGE_SHIFT = 12,
  parameter int COL_LO     = 1,
  parameter int COL_W      = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          err_addr_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       xl_req_valid_o,
  input  logic                       xl_req_ready_i,
  output logic [ADDR_W-1:0]          xl_req_addr_o,
  input  logic                       xl_rsp_valid_i,
  input  logic                       xl_rsp_err_i,
  input  logic [PA_W-1:0]            xl_rsp_pa_i,
  input  logic                       xl_rsp_online_i,
  input  logic                       xl_rsp_poisoned_i,
  output logic                       ret_valid_o,
  input  logic                       ret_ready_i,
  output logic [PA_W-PAGE_SHIFT-1:0] ret_pfn_o
);
  logic              keep, ret_fire, rsp_take;
  logic [COL_W-1:0]  col;
  logic [ADDR_W-1:0] base;

  sweep_ctrl #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .err_addr_i  (err_addr_i),
    .req_ready_i (xl_req_ready_i),
    .rsp_valid_i (xl_rsp_valid_i),
    .keep_i      (keep),
    .ret_fire_i  (ret_fire),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .req_valid_o (xl_req_valid_o),
    .rsp_take_o  (rsp_take),
    .col_o       (col),
    .base_o      (base)
  );

  col_insert #(.ADDR_W(ADDR_W), .COL_LO(COL_LO), .COL_W(COL_W)) u_ins (
    .base_i (base),
    .col_i  (col),
    .addr_o (xl_req_addr_o)
  );

  page_filter #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (rsp_take),
    .err_i      (xl_rsp_err_i),
    .online_i   (xl_rsp_online_i),
    .poisoned_i (xl_rsp_poisoned_i),
    .pa_i       (xl_rsp_pa_i),
    .ready_i    (ret_ready_i),
    .keep_o     (keep),
    .fire_o     (ret_fire),
    .valid_o    (ret_valid_o),
    .pfn_o      (ret_pfn_o)
  );

  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xl_req_valid_o && ret_valid_o));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !xl_req_valid_o && !ret_valid_o);
endmodule

// File: tb/sim_row_col_sweeper.sv
module sim_row_col_sweeper;
  localparam int ADDR_W = 48;
  localparam int PA_W   = 52;
  localparam int PS     = 12;
  localparam int PFN_W  = PA_W - PS;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [ADDR_W-1:0] err_addr_i = '0;
  logic busy_o, done_o, xl_req_valid_o, ret_valid_o;
  logic xl_req_ready_i = 1'b0;
  logic [ADDR_W-1:0] xl_req_addr_o;
  logic xl_rsp_valid_i = 1'b0, xl_rsp_err_i = 1'b0;
  logic [PA_W-1:0] xl_rsp_pa_i = '0;
  logic xl_rsp_online_i = 1'b0, xl_rsp_poisoned_i = 1'b0;
  logic ret_ready_i = 1'b0;
  logic [PFN_W-1:0] ret_pfn_o;

  always #4 clk = ~clk;  // 125 MHz

  row_col_sweeper u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .err_addr_i(err_addr_i),
    .busy_o(busy_o), .done_o(done_o),
    .xl_req_valid_o(xl_req_valid_o), .xl_req_ready_i(xl_req_ready_i),
    .xl_req_addr_o(xl_req_addr_o),
    .xl_rsp_valid_i(xl_rsp_valid_i), .xl_rsp_err_i(xl_rsp_err_i),
    .xl_rsp_pa_i(xl_rsp_pa_i), .xl_rsp_online_i(xl_rsp_online_i),
    .xl_rsp_poisoned_i(xl_rsp_poisoned_i),
    .ret_valid_o(ret_valid_o), .ret_ready_i(ret_ready_i), .ret_pfn_o(ret_pfn_o)
  );

  int n_tests = 0, n_fail = 0;
  logic active;
  int n_req, n_exp, n_got;
  logic [PFN_W-1:0] exp_pfn [0:31];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] put_col(input logic [ADDR_W-1:0] a, input int c);
    logic [ADDR_W-1:0] r = a;
    r[5:1] = c[4:0];
    return r;
  endfunction

  // kind: 0 ok, 1 error, 2 offline, 3 poisoned
  function automatic int kind_of(input int scn, input int c);
    if (scn == 1) return c % 4;
    if (scn == 2) return 1;
    return 0;
  endfunction

  function automatic logic [PA_W-1:0] pa_of(input int scn, input int c);
    return 52'h0_1234_5000_0000 + (PA_W'(c) << 13) + PA_W'(c * 3) + PA_W'(scn);
  endfunction

  task automatic sweep(input int scn, input logic [ADDR_W-1:0] addr, input int req_stall,
                       input int ret_stall, input int exp_ret, input bit late_start);
    int dones;
    n_req = 0; n_exp = 0; n_got = 0; dones = 0;
    @(negedge clk);
    err_addr_i = addr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R8 busy after start", 64'(busy_o), 64'd1);
    active = 1'b1;
    fork
      begin : translator
        while (active) begin
          @(negedge clk);
          if (xl_req_valid_o && active) begin
            logic [ADDR_W-1:0] a0 = xl_req_addr_o;
            int k = kind_of(scn, n_req);
            chk(a0 === put_col(addr, n_req), "R2 request address", 64'(a0), 64'(put_col(addr, n_req)));
            for (int s = 0; s < req_stall; s++) begin
              @(negedge clk);
              chk(xl_req_valid_o && xl_req_addr_o === a0, "R10 request held", 64'(xl_req_addr_o), 64'(a0));
            end
            xl_req_ready_i = 1'b1;
            @(negedge clk);
            xl_req_ready_i = 1'b0;
            @(negedge clk);
            xl_rsp_valid_i = 1'b1;
            xl_rsp_err_i = (k == 1);
            xl_rsp_online_i = (k != 2);
            xl_rsp_poisoned_i = (k == 3);
            xl_rsp_pa_i = pa_of(scn, n_req);
            if (k == 0) begin
              exp_pfn[n_exp] = pa_of(scn, n_req) >> PS;
              n_exp++;
            end
            n_req++;
            @(negedge clk);
            xl_rsp_valid_i = 1'b0;
            chk(!xl_req_valid_o || ret_valid_o === 1'b0, "R3 no overlap", 64'(ret_valid_o), 64'd0);
          end
        end
      end
      begin : consumer
        while (active) begin
          @(negedge clk);
          if (ret_valid_o && active) begin
            logic [PFN_W-1:0] p0 = ret_pfn_o;
            for (int s = 0; s < ret_stall; s++) begin
              @(negedge clk);
              chk(ret_valid_o && ret_pfn_o === p0, "R7 retire held", 64'(ret_pfn_o), 64'(p0));
              chk(!xl_req_valid_o, "R3 no request while retire pending", 64'(xl_req_valid_o), 64'd0);
            end
            chk(p0 === exp_pfn[n_got], "R5 pfn value", 64'(p0), 64'(exp_pfn[n_got]));
            n_got++;
            ret_ready_i = 1'b1;
            @(negedge clk);
            ret_ready_i = 1'b0;
          end
        end
      end
      begin : waiter
        int t = 0;
        if (late_start) begin
          repeat (40) @(negedge clk);
          err_addr_i = ~addr; start_i = 1'b1;
          @(negedge clk);
          start_i = 1'b0;
        end
        while (!done_o && t < 20000) begin
          @(negedge clk); t++;
        end
        if (done_o) begin
          dones++;
          chk(busy_o === 1'b1, "R8 busy in done cycle", 64'(busy_o), 64'd1);
          @(negedge clk);
          chk(done_o === 1'b0 && busy_o === 1'b0, "R8 done single pulse", 64'({done_o, busy_o}), 64'd0);
        end
        active = 1'b0;
      end
    join
    chk(dones == 1, "R8 done seen", 64'(dones), 64'd1);
    chk(n_req == 32, "R3 request count", 64'(n_req), 64'd32);
    chk(n_got == exp_ret, "R4 R6 retire count", 64'(n_got), 64'(exp_ret));
    repeat (12) begin
      @(negedge clk);
      if (busy_o || done_o || xl_req_valid_o) begin
        chk(1'b0, "R9 no extra sweep", 64'({busy_o, done_o, xl_req_valid_o}), 64'd0);
      end
    end
    chk(!busy_o, "R9 idle after sweep", 64'(busy_o), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy_o && !done_o && !xl_req_valid_o && !ret_valid_o, "R1 reset state",
        64'({busy_o, done_o, xl_req_valid_o, ret_valid_o}), 64'd0);
  endtask

  task automatic t_all_ok;      sweep(0, 48'hA5A5_F00D_C03F, 0, 0, 32, 1'b0); endtask
  task automatic t_mixed_stall; sweep(1, 48'h0123_4567_89FF, 2, 3, 8, 1'b0);  endtask
  task automatic t_all_err;     sweep(2, 48'h7FFF_0000_0021, 0, 0, 0, 1'b0);  endtask
  task automatic t_late_start;  sweep(0, 48'h1357_9BDF_0003, 1, 1, 32, 1'b1); endtask

  initial begin
    active = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_all_ok();
    t_mixed_stall();
    t_all_err();
    t_late_start();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule